// File: doc/BRIEF.md
# Timer and Falling-Edge Event Counter

This block holds an 8-bit up-counter that advances from one of two sources. In timer mode it advances on a slow internal tick. The tick comes from two chained dividers: an instruction-cycle divider of 15 clocks, followed by a divide-by-32 prescaler. That gives one tick per 480 clocks. In event mode it advances on each high-to-low transition of an external pin. The pin is first passed through a synchroniser.

Software drives the block with single-cycle command strobes: run as timer, run as event counter, halt, and load a value. The count is always visible. When the count rolls over from all ones to zero, a sticky overflow flag is set. A test strobe reads that flag and clears it. When interrupts are enabled, the rollover also raises an interrupt request, which stays up until it is acknowledged. Counting carries on past the rollover and is never reloaded.

Top module: `tevc_timer`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, the interrupt request is 0 and the counter is halted.
- R2: In timer mode the count advances by one every 480 clocks. The first advance lands exactly 480 clock edges after the edge that samples the timer start strobe, because that start also clears the prescaler.
- R3: In event mode the count advances by one for each 1-to-0 transition of the event pin. The advance lands on the third clock edge after the pin is sampled low. A 0-to-1 transition leaves the count unchanged.
- R4: After a halt strobe, the count holds its value no matter what the event pin or the internal tick do.
- R5: An advance from 0xFF gives 0x00 and sets the overflow flag. The next advance gives 0x01, with no reload.
- R6: The overflow flag stays set until a test strobe is sampled, and reads 0 from the next cycle on. If an overflow occurs in the same cycle as the test strobe, the flag stays set.
- R7: An overflow with the interrupt enable high raises the interrupt request, which holds until an acknowledge strobe is sampled. An overflow with the enable low leaves the request at 0.
- R8: A load strobe puts the load value on the count in the next cycle, even if an advance would occur in that same cycle.
- R9: In timer mode, transitions on the event pin do not change the count. In event mode, only pin transitions advance the count.
- R10: A halt strobe wins over a start strobe in the same cycle. A timer start wins over an event start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_tmr_i | input | 1 | Strobe: run in timer mode, clear the prescaler |
| start_evt_i | input | 1 | Strobe: run in event mode |
| stop_i | input | 1 | Strobe: halt counting |
| load_i | input | 1 | Strobe: write load_val_i into the count |
| load_val_i | input | 8 | Value for a load |
| evt_pin_i | input | 1 | Asynchronous external event input |
| flag_test_i | input | 1 | Strobe: test-and-clear of the overflow flag |
| irq_en_i | input | 1 | Interrupt enable for overflow |
| irq_ack_i | input | 1 | Strobe: acknowledge the pending interrupt |
| count_o | output | 8 | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Pending overflow interrupt request |

## Verification
The hardest case to reach from the ports is a rollover in timer mode. Counting up from zero would take over a hundred thousand clocks. The bench therefore halts the counter, loads 0xFF and restarts the timer, so the wrap, the flag and the interrupt all fall exactly 480 edges later. The run then goes on to the follow-on count of 0x01.

The collision of a load with an advance is reached by timing a pin fall so that the synchroniser's edge pulse meets a load strobe in the same cycle. In event mode the bench also walks the count through all 256 values with counted pin falls.

// File: rtl/tevc_pkg.sv
package tevc_pkg;
   typedef enum logic [1:0] {
      RUN_IDLE  = 2'd0,
      RUN_TIMER = 2'd1,
      RUN_EVENT = 2'd2
   } run_mode_e;
endpackage

// File: rtl/tevc_prescale.sv
// Two chained dividers: an instruction-cycle strobe every CYC_DIV clocks, then
// one tick every PRE_DIV strobes. clr_i restarts both from zero.
module tevc_prescale #(
   parameter int CYC_DIV = 15,
   parameter int PRE_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int CW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
   localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic strobe;
   logic pre_wrap;

   generate
      if (CYC_DIV == 1) begin : g_cyc_bypass
         assign strobe = 1'b1;
      end else begin : g_cyc_div
         logic [CW-1:0] cyc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cyc_q <= '0;
            else if (clr_i)                    cyc_q <= '0;
            else if (cyc_q == CW'(CYC_DIV-1))  cyc_q <= '0;
            else                               cyc_q <= cyc_q + CW'(1);
         end
         assign strobe = (cyc_q == CW'(CYC_DIV-1));
      end

      if (PRE_DIV == 1) begin : g_pre_bypass
         assign pre_wrap = 1'b1;
      end else begin : g_pre_div
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clr_i) pre_q <= '0;
            else if (strobe) begin
               if (pre_q == PW'(PRE_DIV-1)) pre_q <= '0;
               else                         pre_q <= pre_q + PW'(1);
            end
         end
         assign pre_wrap = (pre_q == PW'(PRE_DIV-1));
      end
   endgenerate

   assign tick_o = strobe & pre_wrap & ~clr_i;
endmodule

// File: rtl/tevc_edge_sync.sv
// Synchronises an asynchronous pin and gives a one-cycle pulse on each 1-to-0 change.
module tevc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);
   logic [STAGES-1:0] sr_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], pin_i};
         prev_q <= sr_q[STAGES-1];
      end
   end

   assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/tevc_core.sv
// Holds the run mode, the count, the sticky flag and the interrupt request.
module tevc_core
   import tevc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_tmr_i,
   input  logic             start_evt_i,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             fall_i,
   input  logic             flag_test_i,
   input  logic             irq_en_i,
   input  logic             irq_ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             flag_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   run_mode_e        mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q, irq_q;
   logic             adv, wrap;

   // Priority: halt, then timer start, then event start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mode_q <= RUN_IDLE;
      else if (stop_i)      mode_q <= RUN_IDLE;
      else if (start_tmr_i) mode_q <= RUN_TIMER;
      else if (start_evt_i) mode_q <= RUN_EVENT;
   end

   assign adv  = ((mode_q == RUN_TIMER) & tick_i) | ((mode_q == RUN_EVENT) & fall_i);
   assign wrap = adv & ~load_i & (cnt_q == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (adv)    cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (wrap)        flag_q <= 1'b1;
      else if (flag_test_i) flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_q <= 1'b0;
      else if (wrap && irq_en_i) irq_q <= 1'b1;
      else if (irq_ack_i)        irq_q <= 1'b0;
   end

   assign count_o = cnt_q;
   assign flag_o  = flag_q;
   assign irq_o   = irq_q;
endmodule

// File: rtl/tevc_timer.sv
module tevc_timer #(
   parameter int CNT_W       = 8,
   parameter int CYC_DIV     = 15,
   parameter int PRE_DIV     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_tmr_i,
   input  logic             start_evt_i,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             evt_pin_i,
   input  logic             flag_test_i,
   input  logic             irq_en_i,
   input  logic             irq_ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             flag_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 2)       begin : g_bad_w   $error("CNT_W must be at least 2");       end
      if (CYC_DIV < 1)     begin : g_bad_cyc $error("CYC_DIV must be at least 1");     end
      if (PRE_DIV < 1)     begin : g_bad_pre $error("PRE_DIV must be at least 1");     end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic tick, fall;

   tevc_prescale #(.CYC_DIV(CYC_DIV), .PRE_DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_i(start_tmr_i), .tick_o(tick)
   );

   tevc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(evt_pin_i), .fall_o(fall)
   );

   tevc_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .start_tmr_i(start_tmr_i), .start_evt_i(start_evt_i), .stop_i(stop_i),
      .load_i(load_i), .load_val_i(load_val_i),
      .tick_i(tick), .fall_i(fall),
      .flag_test_i(flag_test_i), .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i),
      .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
   );
endmodule

// File: rtl/tevc_timer_chk.sv
module tevc_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_i,
   input logic             load_i,
   input logic [CNT_W-1:0] load_val_i,
   input logic             flag_test_i,
   input logic             irq_en_i,
   input logic             irq_ack_i,
   input logic [CNT_W-1:0] count_o,
   input logic             flag_o,
   input logic             irq_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_o == $past(load_val_i));

   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

   assert_hold_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stop_i) && !load_i) |=> $stable(count_o));

   assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_i) && $past(count_o) == TOP && count_o == '0) |-> flag_o);

   assert_test_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_test_i && count_o != TOP) |=> !flag_o);

   assert_irq_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> flag_o);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && count_o != TOP) |=> !irq_o);

   assert_no_irq_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_i && !irq_o) |=> !irq_o);
endmodule

bind tevc_timer tevc_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .load_i(load_i),
   .load_val_i(load_val_i), .flag_test_i(flag_test_i), .irq_en_i(irq_en_i),
   .irq_ack_i(irq_ack_i), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/tevc_timer_test.sv
module tevc_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_tmr_i = 1'b0, start_evt_i = 1'b0, stop_i = 1'b0, load_i = 1'b0;
   logic [7:0] load_val_i = '0;
   logic       evt_pin_i = 1'b1;
   logic       flag_test_i = 1'b0, irq_en_i = 1'b0, irq_ack_i = 1'b0;
   logic [7:0] count_o;
   logic       flag_o, irq_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tevc_timer uut (
      .clk(clk), .rst_n(rst_n), .start_tmr_i(start_tmr_i), .start_evt_i(start_evt_i),
      .stop_i(stop_i), .load_i(load_i), .load_val_i(load_val_i), .evt_pin_i(evt_pin_i),
      .flag_test_i(flag_test_i), .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i),
      .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Drives strobes for one sampling edge; returns at the following negedge.
   task automatic cmd(input bit st, input bit se, input bit sp, input bit ld, input logic [7:0] v);
      @(negedge clk);
      start_tmr_i = st; start_evt_i = se; stop_i = sp; load_i = ld; load_val_i = v;
      @(posedge clk);
      @(negedge clk);
      start_tmr_i = 0; start_evt_i = 0; stop_i = 0; load_i = 0;
   endtask

   // One low pulse on the event pin (called at a negedge), checking the count after each half.
   task automatic fall_evt(input string req, input logic [7:0] exp_after);
      evt_pin_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req, count_o, exp_after);
      evt_pin_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({req, " rising ignored R3"}, count_o, exp_after);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 count", count_o, 0);
      chk("R1 flag", flag_o, 0);
      chk("R1 irq", irq_o, 0);

      // R8 load every value
      for (int v = 0; v < 256; v++) begin
         cmd(0, 0, 0, 1, 8'(v));
         chk("R8 load", count_o, v);
      end

      // R2 timer period, R9 pin ignored in timer mode
      cmd(0, 0, 0, 1, 8'h00);
      cmd(1, 0, 0, 0, 8'h00);
      for (int i = 1; i < 480; i++) begin
         @(posedge clk);
         @(negedge clk);
         evt_pin_i = i[2];
      end
      chk("R2/R9 before first tick", count_o, 0);
      evt_pin_i = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R2 first tick", count_o, 1);
      repeat (479) @(posedge clk);
      @(negedge clk);
      chk("R2 before second tick", count_o, 1);
      @(posedge clk); @(negedge clk);
      chk("R2 second tick", count_o, 2);

      // R5/R7 timer wrap with interrupt enabled
      cmd(0, 0, 1, 0, 8'h00);
      cmd(0, 0, 0, 1, 8'hFF);
      irq_en_i = 1'b1;
      cmd(1, 0, 0, 0, 8'h00);
      repeat (479) @(posedge clk);
      @(negedge clk);
      chk("R5 before wrap", count_o, 8'hFF);
      chk("R5 flag before wrap", flag_o, 0);
      @(posedge clk); @(negedge clk);
      chk("R5 wrap count", count_o, 0);
      chk("R5 wrap flag", flag_o, 1);
      chk("R7 irq raised", irq_o, 1);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R7 irq held", irq_o, 1);
      irq_ack_i = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_ack_i = 1'b0;
      chk("R7 irq acked", irq_o, 0);
      chk("R6 flag survives ack", flag_o, 1);
      flag_test_i = 1'b1;
      @(posedge clk); @(negedge clk);
      flag_test_i = 1'b0;
      chk("R6 flag cleared", flag_o, 0);
      repeat (472) @(posedge clk);
      @(negedge clk);
      chk("R5 continue pre", count_o, 0);
      @(posedge clk); @(negedge clk);
      chk("R5 continue no reload", count_o, 1);

      // R3 event sweep over all 256 values, interrupts disabled
      irq_en_i = 1'b0;
      cmd(0, 0, 1, 0, 8'h00);
      cmd(0, 0, 0, 1, 8'h00);
      cmd(0, 1, 0, 0, 8'h00);
      for (int k = 0; k < 256; k++) begin
         fall_evt("R3 event count", 8'((k + 1) & 8'hFF));
         if (k == 254) chk("R5 no flag before wrap", flag_o, 0);
      end
      chk("R5 event wrap flag", flag_o, 1);
      chk("R7 no irq when disabled", irq_o, 0);
      fall_evt("R5 event continue", 8'h01);
      flag_test_i = 1'b1;
      @(posedge clk); @(negedge clk);
      flag_test_i = 1'b0;
      chk("R6 event flag cleared", flag_o, 0);

      // R8 load collides with an increment
      evt_pin_i = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      load_i = 1'b1; load_val_i = 8'h40;
      @(posedge clk); @(negedge clk);
      load_i = 1'b0;
      chk("R8 load beats increment", count_o, 8'h40);
      evt_pin_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 no late increment", count_o, 8'h40);

      // R4 halted counter ignores pin
      cmd(0, 0, 1, 0, 8'h00);
      fall_evt("R4 halted", 8'h40);
      fall_evt("R4 halted again", 8'h40);

      // R10 halt beats start
      cmd(0, 1, 1, 0, 8'h00);
      fall_evt("R10 stop wins", 8'h40);

      // R10 timer start beats event start
      cmd(1, 1, 0, 0, 8'h00);
      fall_evt("R10/R9 timer chosen", 8'h40);
      repeat (473) @(posedge clk);
      @(negedge clk);
      chk("R10 before tick", count_o, 8'h40);
      @(posedge clk); @(negedge clk);
      chk("R10 timer tick", count_o, 8'h41);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule